// File: doc/BRIEF.md
# SPI-Mode Memory Card Command Engine

This block issues a single command to a memory card running in SPI mode and gathers the card's reply. The host provides a 6-bit command index, a 32-bit argument and a reply format, then pulses `start`. The engine asserts chip select and sends the framed command one byte at a time through a byte-wide SPI shifter. It then clocks idle bytes until the card's status byte appears, collects any extra reply bytes, clocks one last idle byte and releases chip select. A one-cycle `done` pulse reports the outcome: success, timeout or card error.

A second entry, `init_start`, runs the card power-up preamble. Chip select stays high while a run of all-ones bytes is clocked out. Each command sets its own SCK rate: the reset command (index 0) uses the slow divider and every other index uses the faster one. The clock rate, retry bound and preamble length are parameters.

Top module: `card_cmd_engine`

## Requirements
- R1: A command sends eight bytes while chip select is low, in this order: 0xFF, then 0x40 OR the 6-bit index, then the argument bytes from bits 31:24 down to bits 7:0, then a check byte, then 0xFF.
- R2: The check byte is 0x95 for index 0, 0x87 for index 8 and 0x00 for every other index.
- R3: Bytes move most significant bit first in SPI mode 0. SCK idles low. MOSI changes only on the falling edge or while SCK is low. MISO is sampled on the rising edge.
- R4: After the frame, the engine clocks bytes with MOSI held high. The first byte it receives with bit 7 clear is the status byte.
- R5: If RETRY_LIMIT polled bytes all have bit 7 set, the command ends with `err` = 1 (timeout). A status byte that arrives on poll number RETRY_LIMIT is still accepted.
- R6: With `rsp_mode` = 1, one more byte is read after the status byte and placed in `status[15:8]`; `status[7:0]` holds the status byte.
- R7: With `rsp_mode` = 2, four more bytes are read, most significant first, into `rsp_word`. With `rsp_mode` = 0 (or 3), no extra bytes are read and `status[15:8]` is zero.
- R8: `err` = 0 when the 16-bit `status` equals 0x0000 or 0x0001. Any other value gives `err` = 2 (card error).
- R9: Index 0 uses SLOW_DIV and all other indices use FAST_DIV. Each SCK half period lasts (N+1) clocks, so rising edges within a byte are 2(N+1) clocks apart.
- R10: `init_start` clocks PWR_BYTES bytes of 0xFF with chip select held high, then pulses `done` with `err` = 0.
- R11: `busy` is high from the cycle after an accepted start until `done`. `done` is high for exactly one cycle, with `busy` low. A `start` or `init_start` that arrives while busy is ignored, and so is a change to the command inputs while busy.
- R12: Chip select is low from the first frame byte through the reply. It rises only after one trailing idle byte, so a command clocks 8 + polls + extra + 1 bytes while selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (sampled when idle) |
| init_start | input | 1 | Begin the power-up preamble (sampled when idle; `start` wins) |
| opcode | input | 6 | Command index |
| arg | input | 32 | Command argument |
| rsp_mode | input | 2 | 0 status only, 1 two-byte status, 2 status plus 32-bit word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 none, 1 timeout, 2 card error; valid with `done` |
| status | output | 16 | Status byte in [7:0], second byte in [15:8] |
| rsp_word | output | 32 | Extra reply word for `rsp_mode` 2 |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to card (idles high) |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | SPI data from card |

## Verification
The assertions assume two things. First, the engine only asks the shifter for a byte while the shifter is idle. Second, the control strobes are pulses of a single cycle. The bench drives `start` and `init_start` for one cycle at a falling system-clock edge, and it deliberately repeats a strobe mid-command only to show that it is ignored. The card model changes MISO right after each SCK rising edge, so the value stays stable for the whole half period before the engine samples it. The model places the status byte after a chosen number of 0xFF bytes, which puts the timeout boundary exactly at RETRY_LIMIT.

// File: rtl/card_cmd_pkg.sv
package card_cmd_pkg;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_CARD    = 2'd2
  } err_code_t;

  typedef enum logic [1:0] {
    RSP_STATUS = 2'd0,
    RSP_TWO    = 2'd1,
    RSP_FOUR   = 2'd2,
    RSP_ALT    = 2'd3
  } rsp_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_FRAME,
    ST_POLL,
    ST_EXTRA,
    ST_TAIL
  } eng_state_t;

  localparam logic [5:0] OP_GO_IDLE  = 6'd0;
  localparam logic [5:0] OP_IF_COND  = 6'd8;
  localparam logic [7:0] CHK_GO_IDLE = 8'h95;
  localparam logic [7:0] CHK_IF_COND = 8'h87;
  localparam logic [7:0] FILL_BYTE   = 8'hFF;
  localparam int         FRAME_LEN   = 8;

  function automatic logic [7:0] check_byte(input logic [5:0] op);
    case (op)
      OP_GO_IDLE: check_byte = CHK_GO_IDLE;
      OP_IF_COND: check_byte = CHK_IF_COND;
      default:    check_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cmd_frame_mux.sv
module cmd_frame_mux
  import card_cmd_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [31:0] arg,
  input  logic [2:0]  sel,
  output logic [7:0]  frame_byte
);

  // Byte order on the wire matters: filler, index, argument MSB..LSB, check, filler.
  always_comb begin
    case (sel)
      3'd0:    frame_byte = FILL_BYTE;
      3'd1:    frame_byte = {2'b01, opcode};
      3'd2:    frame_byte = arg[31:24];
      3'd3:    frame_byte = arg[23:16];
      3'd4:    frame_byte = arg[15:8];
      3'd5:    frame_byte = arg[7:0];
      3'd6:    frame_byte = check_byte(opcode);
      default: frame_byte = FILL_BYTE;
    endcase
  end

endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic [7:0]       rx_byte,
  output logic             done
);

  logic             active;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bitn;
  logic [7:0]       tx_q;
  logic [7:0]       rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      div_q   <= '0;
      bitn    <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      rx_byte <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          tx_q   <= tx_byte;
          mosi   <= tx_byte[7];
          cnt    <= '0;
          bitn   <= '0;
          sck    <= 1'b0;
          div_q  <= div;
        end
      end else if (cnt == div_q) begin
        cnt <= '0;
        if (!sck) begin
          sck  <= 1'b1;
          rx_q <= {rx_q[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            active  <= 1'b0;
            done    <= 1'b1;
            rx_byte <= rx_q;
            mosi    <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            tx_q <= {tx_q[6:0], 1'b0};
            mosi <= tx_q[6];
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: the engine only requests a byte while the shifter is free
  a_r3_start_when_free: assert property (@(posedge clk) disable iff (rst)
    start |-> !active);

  // R3: data toward the card never moves while SCK is high
  a_r3_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(mosi));

  // R3: a byte completes with SCK back at its idle level
  a_r3_done_sck_low: assert property (@(posedge clk) disable iff (rst)
    done |-> !sck && !active);

endmodule

// File: rtl/card_cmd_engine.sv
module card_cmd_engine
  import card_cmd_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SLOW_DIV    = 144,
  parameter int FAST_DIV    = 48,
  parameter int RETRY_LIMIT = 1000,
  parameter int PWR_BYTES   = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        init_start,
  input  logic [5:0]  opcode,
  input  logic [31:0] arg,
  input  logic [1:0]  rsp_mode,
  output logic        busy,
  output logic        done,
  output logic [1:0]  err,
  output logic [15:0] status,
  output logic [31:0] rsp_word,
  output logic        sck,
  output logic        mosi,
  output logic        cs_n,
  input  logic        miso
);

  localparam int CNT_MAX = (RETRY_LIMIT > PWR_BYTES) ? RETRY_LIMIT : PWR_BYTES;
  localparam int CNT_W   = (CNT_MAX < 8) ? 4 : $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] RETRY_MAX  = CNT_W'(RETRY_LIMIT);
  localparam logic [CNT_W-1:0] PWR_LAST   = CNT_W'(PWR_BYTES - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [DIV_W-1:0] DIV_SLOW   = DIV_W'(SLOW_DIV);
  localparam logic [DIV_W-1:0] DIV_FAST   = DIV_W'(FAST_DIV);

  eng_state_t       state;
  rsp_mode_t        mode_q;
  err_code_t        err_q;
  logic [5:0]       op_q;
  logic [31:0]      arg_q;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] retry;
  logic [DIV_W-1:0] div_q;
  logic             kick;
  logic             timed_out;
  logic [7:0]       frame_byte;
  logic [7:0]       tx_byte;
  logic [7:0]       rx_byte;
  logic             sh_done;

  cmd_frame_mux u_frame (
    .opcode     (op_q),
    .arg        (arg_q),
    .sel        (idx[2:0]),
    .frame_byte (frame_byte)
  );

  assign tx_byte = (state == ST_FRAME) ? frame_byte : FILL_BYTE;

  spi_byte_shift #(.DIV_W(DIV_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (kick),
    .div     (div_q),
    .tx_byte (tx_byte),
    .miso    (miso),
    .sck     (sck),
    .mosi    (mosi),
    .rx_byte (rx_byte),
    .done    (sh_done)
  );

  assign busy = (state != ST_IDLE);
  assign err  = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= RSP_STATUS;
      err_q     <= ERR_NONE;
      op_q      <= '0;
      arg_q     <= '0;
      idx       <= '0;
      retry     <= '0;
      div_q     <= DIV_SLOW;
      kick      <= 1'b0;
      timed_out <= 1'b0;
      status    <= '0;
      rsp_word  <= '0;
      cs_n      <= 1'b1;
      done      <= 1'b0;
    end else begin
      kick <= 1'b0;
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            op_q      <= opcode;
            arg_q     <= arg;
            mode_q    <= rsp_mode_t'(rsp_mode);
            div_q     <= (opcode == OP_GO_IDLE) ? DIV_SLOW : DIV_FAST;
            cs_n      <= 1'b0;
            idx       <= '0;
            retry     <= '0;
            timed_out <= 1'b0;
            status    <= '0;
            rsp_word  <= '0;
            kick      <= 1'b1;
            state     <= ST_FRAME;
          end else if (init_start) begin
            div_q <= DIV_SLOW;
            idx   <= '0;
            kick  <= 1'b1;
            state <= ST_PWR;
          end
        end
        ST_PWR: begin
          if (sh_done) begin
            if (idx == PWR_LAST) begin
              done  <= 1'b1;
              err_q <= ERR_NONE;
              state <= ST_IDLE;
            end else begin
              idx  <= idx + 1'b1;
              kick <= 1'b1;
            end
          end
        end
        ST_FRAME: begin
          if (sh_done) begin
            kick <= 1'b1;
            if (idx == FRAME_LAST) begin
              retry <= CNT_W'(1);
              state <= ST_POLL;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_POLL: begin
          if (sh_done) begin
            kick <= 1'b1;
            if (!rx_byte[7]) begin
              status <= {8'h00, rx_byte};
              idx    <= '0;
              state  <= (mode_q == RSP_TWO || mode_q == RSP_FOUR) ? ST_EXTRA : ST_TAIL;
            end else if (retry == RETRY_MAX) begin
              timed_out <= 1'b1;
              state     <= ST_TAIL;
            end else begin
              retry <= retry + 1'b1;
            end
          end
        end
        ST_EXTRA: begin
          if (sh_done) begin
            kick <= 1'b1;
            if (mode_q == RSP_TWO) begin
              status[15:8] <= rx_byte;
              state        <= ST_TAIL;
            end else begin
              rsp_word <= {rsp_word[23:0], rx_byte};
              if (idx == CNT_W'(3)) state <= ST_TAIL;
              else                  idx   <= idx + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (sh_done) begin
            cs_n  <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
            if (timed_out)                               err_q <= ERR_TIMEOUT;
            else if (status == 16'h0000 || status == 16'h0001) err_q <= ERR_NONE;
            else                                         err_q <= ERR_CARD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: completion is a single-cycle pulse
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: the engine is free again when it reports completion
  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R12: chip select is released whenever the engine is idle
  a_r12_cs_idle_high: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> cs_n);

  // R10: the preamble never selects the card
  a_r10_pwr_cs_high: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PWR) |-> cs_n);

  // R5: the poll count stays within the retry bound
  a_r5_retry_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POLL) |-> (retry != '0) && (retry <= RETRY_MAX));

  // R4: the card is selected while polling and reading the reply
  a_r4_cs_low_poll: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POLL || state == ST_EXTRA) |-> !cs_n);

endmodule

// File: tb/card_cmd_engine_test.sv
module card_cmd_engine_test;

  localparam int SLOW = 3;
  localparam int FAST = 1;
  localparam int RETRIES = 16;
  localparam int WAIT_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        init_start = 1'b0;
  logic [5:0]  opcode = '0;
  logic [31:0] arg = '0;
  logic [1:0]  rsp_mode = '0;
  logic        busy, done, sck, mosi, cs_n, miso;
  logic [1:0]  err;
  logic [15:0] status;
  logic [31:0] rsp_word;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  card_cmd_engine #(
    .SLOW_DIV(SLOW), .FAST_DIV(FAST), .RETRY_LIMIT(RETRIES), .PWR_BYTES(20)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .init_start(init_start),
    .opcode(opcode), .arg(arg), .rsp_mode(rsp_mode),
    .busy(busy), .done(done), .err(err), .status(status), .rsp_word(rsp_word),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  // ---------------- card model ----------------
  int         rx_count;
  logic [2:0] bitcnt;
  logic [7:0] shin;
  logic [7:0] cur_out;
  logic [7:0] cap [0:63];
  int         busy_n;
  logic [7:0] resp [0:4];
  int         resp_len;
  int         pu_bits, pu_zero, cs_falls, done_count;
  int         cyc, last_rise, rise_gap;

  function automatic logic [7:0] card_byte(input int n);
    int k;
    if (n < 8) return 8'hFF;
    k = n - 8;
    if (k < busy_n) return 8'hFF;
    k = k - busy_n;
    if (k < resp_len) return resp[k];
    return 8'hFF;
  endfunction

  assign miso = cs_n ? 1'b1 : cur_out[3'd7 - bitcnt];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (done) done_count = done_count + 1;
  end

  always @(negedge cs_n) cs_falls = cs_falls + 1;

  always @(posedge sck) begin
    rise_gap  = cyc - last_rise;
    last_rise = cyc;
    if (!cs_n) begin
      shin = {shin[6:0], mosi};
      if (bitcnt == 3'd7) begin
        if (rx_count < 64) cap[rx_count] = shin;
        rx_count = rx_count + 1;
        cur_out  = card_byte(rx_count);
        bitcnt   = 3'd0;
      end else begin
        bitcnt = bitcnt + 3'd1;
      end
    end else begin
      pu_bits = pu_bits + 1;
      if (!mosi) pu_zero = pu_zero + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup_card(input int nbusy, input int len, input logic [39:0] bytes);
    busy_n   = nbusy;
    resp_len = len;
    for (int i = 0; i < 5; i++) resp[i] = bytes[39 - 8*i -: 8];
    rx_count = 0;
    bitcnt   = 3'd0;
    cur_out  = 8'hFF;
    shin     = 8'h00;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < WAIT_LIMIT) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog R11 actual=no_done expected=done");
    end
  endtask

  task automatic issue(input logic [5:0] op, input logic [31:0] a, input logic [1:0] m);
    @(negedge clk);
    opcode = op; arg = a; rsp_mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 busy after start", {39'd0, busy}, 40'd1);
  endtask

  task automatic chk_frame(input string req, input logic [5:0] op, input logic [31:0] a, input logic [7:0] crc);
    chk(req, {cap[0], cap[1], cap[2], cap[3], cap[4]}, {8'hFF, 2'b01, op, a[31:24], a[23:16], a[15:8]});
    chk(req, {16'd0, cap[5], cap[6], cap[7]}, {16'd0, a[7:0], crc, 8'hFF});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R12 reset cs_n/busy/done/sck/mosi", {35'd0, cs_n, busy, done, sck, mosi}, {35'd0, 5'b10001});
  endtask

  task automatic t_powerup();
    int falls0 = cs_falls;
    pu_bits = 0; pu_zero = 0;
    @(negedge clk); init_start = 1'b1;
    @(negedge clk); init_start = 1'b0;
    wait_done();
    chk("R10 preamble bit count", 40'(pu_bits), 40'd160);
    chk("R10 preamble all ones", 40'(pu_zero), 40'd0);
    chk("R10 cs_n held high", 40'(cs_falls - falls0), 40'd0);
    chk("R10 err none", {38'd0, err}, 40'd0);
  endtask

  task automatic t_go_idle();
    setup_card(2, 1, {8'h01, 32'h0});
    issue(6'd0, 32'h0, 2'd0);
    wait_done();
    chk_frame("R1 R2 go-idle frame", 6'd0, 32'h0, 8'h95);
    chk("R4 R8 status idle ok", {22'd0, status, err}, {22'd0, 16'h0001, 2'd0});
    chk("R9 slow rise gap", 40'(rise_gap), 40'(2*(SLOW+1)));
    chk("R12 bytes while selected", 40'(rx_count), 40'(8+3+1));
    chk("R12 cs_n high at done", {39'd0, cs_n}, 40'd1);
  endtask

  task automatic t_if_cond();
    setup_card(1, 5, {8'h01, 8'h00, 8'h00, 8'h01, 8'hAA});
    issue(6'd8, 32'h0000_01AA, 2'd2);
    wait_done();
    chk_frame("R2 if-cond check byte", 6'd8, 32'h0000_01AA, 8'h87);
    chk("R7 four-byte word", {8'd0, rsp_word}, {8'd0, 32'h0000_01AA});
    chk("R7 status", {22'd0, status, err}, {22'd0, 16'h0001, 2'd0});
    chk("R12 bytes four-byte", 40'(rx_count), 40'(8+1+5+1));
  endtask

  task automatic t_read_cmd();
    setup_card(0, 1, {8'h00, 32'h0});
    issue(6'd17, 32'h1234_5678, 2'd0);
    wait_done();
    chk_frame("R1 R3 argument order", 6'd17, 32'h1234_5678, 8'h00);
    chk("R9 fast rise gap", 40'(rise_gap), 40'(2*(FAST+1)));
    chk("R7 no extra, upper zero", {22'd0, status, err}, {22'd0, 16'h0000, 2'd0});
  endtask

  task automatic t_two_byte();
    setup_card(3, 2, {8'h00, 8'h00, 24'h0});
    issue(6'd13, 32'h0, 2'd1);
    wait_done();
    chk("R6 two-byte ok", {22'd0, status, err}, {22'd0, 16'h0000, 2'd0});
    chk("R6 bytes two-byte", 40'(rx_count), 40'(8+3+2+1));
    setup_card(1, 2, {8'h00, 8'h04, 24'h0});
    issue(6'd13, 32'h0, 2'd1);
    wait_done();
    chk("R6 R8 upper byte error", {22'd0, status, err}, {22'd0, 16'h0400, 2'd2});
  endtask

  task automatic t_card_error();
    setup_card(0, 1, {8'h05, 32'h0});
    issue(6'd55, 32'hDEAD_BEEF, 2'd0);
    wait_done();
    chk("R8 card error", {22'd0, status, err}, {22'd0, 16'h0005, 2'd2});
  endtask

  task automatic t_timeout();
    setup_card(RETRIES, 1, {8'h00, 32'h0});
    issue(6'd1, 32'h0, 2'd0);
    wait_done();
    chk("R5 timeout err", {38'd0, err}, 40'd1);
    chk("R5 timeout byte count", 40'(rx_count), 40'(8+RETRIES+1));
    setup_card(RETRIES-1, 1, {8'h00, 32'h0});
    issue(6'd1, 32'h0, 2'd0);
    wait_done();
    chk("R5 last poll accepted", {22'd0, status, err}, {22'd0, 16'h0000, 2'd0});
    chk("R4 polled bytes", 40'(rx_count), 40'(8+RETRIES+1));
  endtask

  task automatic t_ignore_start();
    int d0;
    setup_card(2, 1, {8'h00, 32'h0});
    issue(6'd17, 32'hA5A5_0F0F, 2'd0);
    d0 = done_count;
    repeat (10) @(negedge clk);
    opcode = 6'd2; arg = 32'hFFFF_FFFF; start = 1'b1; init_start = 1'b1;
    @(negedge clk);
    start = 1'b0; init_start = 1'b0;
    wait_done();
    @(negedge clk);
    chk_frame("R11 latched command unchanged", 6'd17, 32'hA5A5_0F0F, 8'h00);
    repeat (200) @(negedge clk);
    chk("R11 one done per command", 40'(done_count - d0), 40'd1);
    chk("R11 idle after ignored start", {38'd0, busy, cs_n}, {38'd0, 2'b01});
  endtask

  initial begin
    cyc = 0; last_rise = 0; rise_gap = 0;
    pu_bits = 0; pu_zero = 0; cs_falls = 0; done_count = 0;
    setup_card(0, 0, 40'h0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_powerup();
    t_go_idle();
    t_if_cond();
    t_read_cmd();
    t_two_byte();
    t_card_error();
    t_timeout();
    t_ignore_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule